// File: doc/BRIEF.md
# Byte-Counted Audio DMA Channel

This block is a single DMA channel that streams audio words between system memory and a codec sample FIFO. Software sets a start byte address and a byte count, then sets the enable bit. The channel then moves 32-bit words whenever the FIFO side has room (playback) or data (capture). Each completed word advances the address by four bytes and lowers the count by four. When the count reaches zero, the channel raises a one-cycle completion interrupt. One stereo frame of 16-bit samples is one word, so every completed word moves one frame.

Work is done in bursts. From the idle state the channel sizes a burst as the smaller of the remaining words and the FIFO words reported as available. A burst of size zero issues no memory request and raises no interrupt. A burst also ends early if the FIFO signals that it can take no more, if the channel is disabled, or if software rewrites the address or count. Memory is reached through a one-word-at-a-time request/grant handshake. The parameter `PLAYBACK` selects the direction: 1 means memory to FIFO, 0 means FIFO to memory.

Top module: `audio_dma_chan`

## Requirements
- R1: After reset, `en_o`, `addr_o`, `remaining_o`, `mem_req` and `irq_done` are all zero.
- R2: A write with `cfg_sel`=1 loads the address and `cfg_sel`=2 loads the byte count, in both cases with bits [1:0] forced to zero. `cfg_sel`=0 loads the enable from `cfg_wdata[0]`. Address and count are readable on `addr_o` and `remaining_o`.
- R3: A burst starts only while the channel is enabled and `fifo_ok` is high. Its length in words is min(`remaining_o`/4, `fifo_level`).
- R4: If that minimum is zero, `mem_req` stays low and no interrupt is raised.
- R5: Every completed word (`mem_req` and `mem_gnt` high at a clock edge) adds 4 to `addr_o` and subtracts 4 from `remaining_o`.
- R6: In playback, each word read at `mem_addr` is pushed to the FIFO in address order, in the cycle of its grant.
- R7: In capture, the FIFO head word is written to memory at `mem_addr` (`mem_we`=1) and popped in the cycle of its grant.
- R8: `irq_done` is high for exactly one cycle. That cycle is the one after an enabled word that brings `remaining_o` to zero.
- R9: When `fifo_ok` is low at a word's grant, the burst ends after that word. The bookkeeping then matches only the words actually moved.
- R10: Clearing the enable stops the channel once the word in flight completes. The address and count keep their values.
- R11: An address or count write made while a word is in flight takes effect only after that word completes.
- R12: While `mem_req` is waiting for a grant, the request and `mem_addr` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Software register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 address, 2 count |
| cfg_wdata | input | 32 | Software write data |
| en_o | output | 1 | Enable bit readback |
| addr_o | output | ADDR_W | Current byte address |
| remaining_o | output | CNT_W | Remaining byte count |
| fifo_level | input | LVL_W | FIFO words free (playback) or held (capture) |
| fifo_ok | input | 1 | FIFO side still accepting or supplying |
| fifo_push | output | 1 | Push strobe into FIFO (playback) |
| fifo_push_data | output | DATA_W | Word pushed into FIFO |
| fifo_pop | output | 1 | Pop strobe from FIFO (capture) |
| fifo_pop_data | input | DATA_W | FIFO head word |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_gnt | input | 1 | Word completes this cycle |
| mem_rdata | input | DATA_W | Read data, valid with grant |
| irq_done | output | 1 | Completion interrupt pulse |

## Verification
The main function is driven with four patterns:
- Zero grant latency with ample FIFO room. This shows back-to-back words and a single interrupt.
- A FIFO smaller than the transfer. Here the burst must stop at the level and resume only after a drain, which tells the level cap apart from the count cap.
- Slow grants combined with `fifo_ok` dropping or the enable clearing mid-burst. These show that the bookkeeping counts only the moved words.
- An address rewrite while a word is in flight, which shows the deferred update.

A capture instance is run with a partly filled FIFO to check write data, address order and pops.

// File: rtl/audio_dma_pkg.sv
package audio_dma_pkg;
    typedef enum logic {ST_IDLE = 1'b0, ST_XFER = 1'b1} dma_st_e;
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_ADDR = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;
endpackage

// File: rtl/audio_dma_sizer.sv
module audio_dma_sizer #(
    parameter int WORD_W = 14,
    parameter int LVL_W  = 6
) (
    input  logic [WORD_W-1:0] rem_words,
    input  logic [LVL_W-1:0]  level,
    output logic [LVL_W-1:0]  burst
);
    localparam int CW = (WORD_W > LVL_W) ? WORD_W : LVL_W;
    logic [CW-1:0] rem_x, lvl_x;

    always_comb begin
        rem_x = CW'(rem_words);
        lvl_x = CW'(level);
        burst = (rem_x < lvl_x) ? LVL_W'(rem_x) : level;
    end
endmodule

// File: rtl/audio_dma_port.sv
module audio_dma_port #(
    parameter bit PLAYBACK = 1'b1,
    parameter int DATA_W   = 32
) (
    input  logic              active,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] fifo_pop_data,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              fifo_push,
    output logic [DATA_W-1:0] fifo_push_data,
    output logic              fifo_pop
);
    assign mem_wdata      = fifo_pop_data;
    assign fifo_push_data = mem_rdata;

    generate
        if (PLAYBACK) begin : g_play
            assign mem_we    = 1'b0;
            assign fifo_push = active & mem_gnt;
            assign fifo_pop  = 1'b0;
        end else begin : g_cap
            assign mem_we    = 1'b1;
            assign fifo_push = 1'b0;
            assign fifo_pop  = active & mem_gnt;
        end
    endgenerate
endmodule

// File: rtl/audio_dma_chan.sv
module audio_dma_chan
    import audio_dma_pkg::*;
#(
    parameter bit PLAYBACK = 1'b1,
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 16,
    parameter int DATA_W   = 32,
    parameter int LVL_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic              en_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CNT_W-1:0]  remaining_o,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              fifo_ok,
    output logic              fifo_push,
    output logic [DATA_W-1:0] fifo_push_data,
    output logic              fifo_pop,
    input  logic [DATA_W-1:0] fifo_pop_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              irq_done
);
    localparam int WORD_W = CNT_W - 2;
    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(4);
    localparam logic [CNT_W-1:0]  CNT_STEP  = CNT_W'(4);

    typedef struct packed {
        dma_st_e            st;
        logic               en;
        logic [ADDR_W-1:0]  addr;
        logic [CNT_W-1:0]   rem;
        logic [LVL_W-1:0]   burst;
        logic               pa_v;
        logic [ADDR_W-1:0]  pa;
        logic               pc_v;
        logic [CNT_W-1:0]   pc;
        logic               irq;
    } regs_t;

    regs_t d, q;
    logic [LVL_W-1:0]  burst_sz;
    logic [ADDR_W-1:0] wr_addr_val;
    logic [CNT_W-1:0]  wr_cnt_val;
    logic              wr_addr, wr_cnt, wr_ctrl, start;

    audio_dma_sizer #(.WORD_W(WORD_W), .LVL_W(LVL_W)) u_sizer (
        .rem_words (q.rem[CNT_W-1:2]),
        .level     (fifo_level),
        .burst     (burst_sz)
    );

    audio_dma_port #(.PLAYBACK(PLAYBACK), .DATA_W(DATA_W)) u_port (
        .active         (q.st == ST_XFER),
        .mem_gnt        (mem_gnt),
        .mem_rdata      (mem_rdata),
        .fifo_pop_data  (fifo_pop_data),
        .mem_we         (mem_we),
        .mem_wdata      (mem_wdata),
        .fifo_push      (fifo_push),
        .fifo_push_data (fifo_push_data),
        .fifo_pop       (fifo_pop)
    );

    always_comb begin
        wr_ctrl     = cfg_we && (cfg_sel == SEL_CTRL);
        wr_addr     = cfg_we && (cfg_sel == SEL_ADDR);
        wr_cnt      = cfg_we && (cfg_sel == SEL_CNT);
        wr_addr_val = {cfg_wdata[ADDR_W-1:2], 2'b00};
        wr_cnt_val  = {cfg_wdata[CNT_W-1:2], 2'b00};
        start       = 1'b0;
        d           = q;
        d.irq       = 1'b0;
        if (wr_ctrl) d.en = cfg_wdata[0];
        case (q.st)
            ST_IDLE: begin
                // deferred writes land here, after the word they waited on
                if (q.pa_v) begin d.addr = q.pa; d.pa_v = 1'b0; end
                if (q.pc_v) begin d.rem  = q.pc; d.pc_v = 1'b0; end
                if (wr_addr) d.addr = wr_addr_val;
                if (wr_cnt)  d.rem  = wr_cnt_val;
                start = q.en && fifo_ok && !q.pa_v && !q.pc_v &&
                        !wr_addr && !wr_cnt && (burst_sz != '0);
                if (start) begin
                    d.st    = ST_XFER;
                    d.burst = burst_sz;
                end
            end
            default: begin
                if (wr_addr) begin d.pa_v = 1'b1; d.pa = wr_addr_val; end
                if (wr_cnt)  begin d.pc_v = 1'b1; d.pc = wr_cnt_val;  end
                if (mem_gnt) begin
                    d.addr  = q.addr + ADDR_STEP;
                    d.rem   = q.rem - CNT_STEP;
                    d.burst = q.burst - LVL_W'(1);
                    d.irq   = q.en && (q.rem == CNT_STEP);
                    if ((q.burst == LVL_W'(1)) || !fifo_ok || !q.en ||
                        q.pa_v || q.pc_v || wr_addr || wr_cnt)
                        d.st = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign en_o        = q.en;
    assign addr_o      = q.addr;
    assign remaining_o = q.rem;
    assign mem_req     = (q.st == ST_XFER);
    assign mem_addr    = q.addr;
    assign irq_done    = q.irq;

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));
    // R5
    word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_gnt |=> (addr_o == $past(addr_o) + ADDR_STEP) &&
                               (remaining_o == $past(remaining_o) - CNT_STEP));
    // R8
    irq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> remaining_o == '0);
    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |=> !irq_done);
    // R4
    zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        remaining_o == '0 |-> !mem_req);
    // R10
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_o && !mem_req |=> !mem_req);
endmodule

// File: tb/sim_audio_dma_chan.sv
`timescale 1ns/1ps
module sim_audio_dma_chan;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // playback instance signals
    logic p_we = 0; logic [1:0] p_sel = 0; logic [31:0] p_wd = 0;
    logic p_en; logic [31:0] p_addr; logic [15:0] p_rem;
    logic [5:0] p_level; logic p_ok = 1;
    logic p_push; logic [31:0] p_push_d; logic p_pop;
    logic p_req, p_mwe; logic [31:0] p_maddr, p_mwd; logic p_gnt = 0;
    logic [31:0] p_rdata; logic p_irq;
    // capture instance signals
    logic c_we = 0; logic [1:0] c_sel = 0; logic [31:0] c_wd = 0;
    logic c_en; logic [31:0] c_addr; logic [15:0] c_rem;
    logic [5:0] c_level; logic c_ok = 1;
    logic c_push; logic [31:0] c_push_d; logic c_pop; logic [31:0] c_head = 0;
    logic c_req, c_mwe; logic [31:0] c_maddr, c_mwd; logic c_gnt = 0;
    logic c_irq;

    audio_dma_chan #(.PLAYBACK(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(p_we), .cfg_sel(p_sel), .cfg_wdata(p_wd),
        .en_o(p_en), .addr_o(p_addr), .remaining_o(p_rem), .fifo_level(p_level),
        .fifo_ok(p_ok), .fifo_push(p_push), .fifo_push_data(p_push_d), .fifo_pop(p_pop),
        .fifo_pop_data(32'h0), .mem_req(p_req), .mem_we(p_mwe), .mem_addr(p_maddr),
        .mem_wdata(p_mwd), .mem_gnt(p_gnt), .mem_rdata(p_rdata), .irq_done(p_irq));

    audio_dma_chan #(.PLAYBACK(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_we(c_we), .cfg_sel(c_sel), .cfg_wdata(c_wd),
        .en_o(c_en), .addr_o(c_addr), .remaining_o(c_rem), .fifo_level(c_level),
        .fifo_ok(c_ok), .fifo_push(c_push), .fifo_push_data(c_push_d), .fifo_pop(c_pop),
        .fifo_pop_data(c_head), .mem_req(c_req), .mem_we(c_mwe), .mem_addr(c_maddr),
        .mem_wdata(c_mwd), .mem_gnt(c_gnt), .mem_rdata(32'h0), .irq_done(c_irq));

    function automatic logic [31:0] word_at(input logic [31:0] a);
        return 32'hA500_0000 ^ {a[15:0], a[15:0]};
    endfunction
    assign p_rdata = word_at(p_maddr);

    // memory models with programmable grant latency
    int p_lat = 0, c_lat = 0, p_wait = 0, c_wait = 0;
    always @(negedge clk) begin
        p_gnt <= 1'b0;
        c_gnt <= 1'b0;
        if (p_req) begin
            if (p_wait >= p_lat) begin p_gnt <= 1'b1; p_wait <= 0; end
            else p_wait <= p_wait + 1;
        end else p_wait <= 0;
        if (c_req) begin
            if (c_wait >= c_lat) begin c_gnt <= 1'b1; c_wait <= 0; end
            else c_wait <= c_wait + 1;
        end else c_wait <= 0;
    end

    // FIFO models
    int p_depth = 16, p_occ = 0;
    assign p_level = 6'(p_depth - p_occ);
    logic [31:0] cap_fifo[$];
    int c_cnt = 0;
    assign c_level = 6'(c_cnt);

    // scoreboards
    logic [31:0] exp_play[$];
    logic [31:0] exp_caddr[$];
    logic [31:0] exp_cdata[$];
    int p_pushes = 0, c_writes = 0, p_irqs = 0, c_irqs = 0;
    int p_req_seen = 0, p_irq_run = 0, p_irq_run_max = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: samples shortly before each rising edge
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (p_req) p_req_seen++;
            if (p_irq) begin p_irqs++; p_irq_run++; end
            else p_irq_run = 0;
            if (p_irq_run > p_irq_run_max) p_irq_run_max = p_irq_run;
            if (c_irq) c_irqs++;
            if (p_push) begin
                p_pushes++;
                p_occ++;
                if (exp_play.size() == 0) chk(1'b0, "R6 unexpected push", p_push_d, 32'h0);
                else begin
                    logic [31:0] e;
                    e = exp_play.pop_front();
                    chk(p_push_d == e, "R6 playback word", p_push_d, e);
                end
            end
            if (c_req && c_gnt) begin
                c_writes++;
                if (exp_caddr.size() == 0) chk(1'b0, "R7 unexpected write", c_maddr, 32'h0);
                else begin
                    logic [31:0] ea, ed;
                    ea = exp_caddr.pop_front();
                    ed = exp_cdata.pop_front();
                    chk(c_maddr == ea, "R7 capture addr", c_maddr, ea);
                    chk(c_mwd == ed && c_mwe && c_pop, "R7 capture data", c_mwd, ed);
                end
            end
            if (c_pop && cap_fifo.size() > 0) begin
                void'(cap_fifo.pop_front());
                c_cnt = cap_fifo.size();
                c_head = (c_cnt > 0) ? cap_fifo[0] : 32'h0;
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pwr(input logic [1:0] sel, input logic [31:0] v);
        @(negedge clk);
        p_we = 1'b1; p_sel = sel; p_wd = v;
        @(negedge clk);
        p_we = 1'b0;
    endtask

    task automatic cwr(input logic [1:0] sel, input logic [31:0] v);
        @(negedge clk);
        c_we = 1'b1; c_sel = sel; c_wd = v;
        @(negedge clk);
        c_we = 1'b0;
    endtask

    task automatic expect_play(input logic [31:0] a, input int n);
        for (int i = 0; i < n; i++) exp_play.push_back(word_at(a + 32'(4 * i)));
    endtask

    task automatic cap_fill(input logic [31:0] a, input int n, input int base);
        for (int i = 0; i < n; i++) begin
            logic [31:0] dv;
            dv = 32'hC0DE_0000 + 32'(base + i);
            cap_fifo.push_back(dv);
            exp_caddr.push_back(a + 32'(4 * i));
            exp_cdata.push_back(dv);
        end
        c_cnt = cap_fifo.size();
        c_head = cap_fifo[0];
    endtask

    task automatic wait_push(input int target);
        for (int i = 0; i < 400 && p_pushes < target; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        int base_push, base_irq;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk(!p_en && p_addr == 0 && p_rem == 0 && !p_req && !p_irq, "R1 reset state",
            {p_en, p_req, p_irq, 13'b0, p_rem}, 32'h0);
        chk(!c_en && c_addr == 0 && c_rem == 0 && !c_req && !c_irq, "R1 capture reset", c_addr, 32'h0);

        // R2 alignment masking on address and count
        pwr(2'd1, 32'h0000_1003);
        pwr(2'd2, 32'h0000_000B);
        cyc(1);
        chk(p_addr == 32'h1000, "R2 address masked", p_addr, 32'h1000);
        chk(p_rem == 16'h0008, "R2 count masked", {16'h0, p_rem}, 32'h8);
        chk(!p_req, "R2 no request while disabled", {31'h0, p_req}, 32'h0);

        // basic playback, zero latency: R3 R5 R6 R8
        p_depth = 16; p_occ = 0; p_lat = 0;
        pwr(2'd1, 32'h0000_0100);
        pwr(2'd2, 32'd12);
        expect_play(32'h100, 3);
        pwr(2'd0, 32'h1);
        wait_push(3);
        cyc(4);
        chk(p_addr == 32'h10C, "R5 final address", p_addr, 32'h10C);
        chk(p_rem == 0, "R5 final count", {16'h0, p_rem}, 32'h0);
        chk(p_irqs == 1, "R8 single interrupt", p_irqs, 1);
        chk(p_irq_run_max == 1, "R8 one-cycle pulse", p_irq_run_max, 1);
        chk(exp_play.size() == 0, "R6 all words seen", exp_play.size(), 0);

        // R4 enabled with zero count: no request, no interrupt
        p_req_seen = 0;
        cyc(20);
        chk(p_req_seen == 0, "R4 zero count idle", p_req_seen, 0);
        chk(p_irqs == 1, "R4 no extra interrupt", p_irqs, 1);

        // R3 burst capped by FIFO room
        p_depth = 4; p_occ = 0; p_lat = 2;
        pwr(2'd1, 32'h0000_0200);
        expect_play(32'h200, 10);
        pwr(2'd2, 32'd40);
        cyc(60);
        chk(p_pushes == 7, "R3 capped by level", p_pushes, 7);
        chk(p_rem == 16'd24, "R3 count after capped burst", {16'h0, p_rem}, 32'd24);
        p_req_seen = 0;
        cyc(10);
        chk(p_req_seen == 0, "R4 full FIFO no request", p_req_seen, 0);
        p_occ = 0;
        wait_push(11);
        cyc(10);
        chk(p_rem == 16'd8, "R3 second burst", {16'h0, p_rem}, 32'd8);
        p_occ = 0;
        wait_push(13);
        cyc(6);
        chk(p_rem == 0 && p_addr == 32'h228, "R5 capped transfer end", p_addr, 32'h228);
        chk(p_irqs == 2, "R8 interrupt after capped transfer", p_irqs, 2);

        // R9 fifo_ok drop mid-burst
        p_depth = 16; p_occ = 0; p_lat = 3;
        base_push = p_pushes;
        pwr(2'd1, 32'h0000_0300);
        expect_play(32'h300, 8);
        pwr(2'd2, 32'd32);
        wait_push(base_push + 1);
        p_ok = 1'b0;
        cyc(20);
        chk(!p_req, "R9 request stopped", {31'h0, p_req}, 32'h0);
        chk(32'(p_rem) + 32'(4 * (p_pushes - base_push)) == 32'd32, "R9 count matches moved",
            32'(p_rem), 32'd32 - 32'(4 * (p_pushes - base_push)));
        chk(p_addr == 32'h300 + 32'(4 * (p_pushes - base_push)) && p_rem != 0, "R9 address matches moved",
            p_addr, 32'h300 + 32'(4 * (p_pushes - base_push)));
        p_ok = 1'b1;
        wait_push(base_push + 8);
        cyc(8);
        chk(p_rem == 0 && p_irqs == 3, "R9 resume to completion", p_irqs, 3);

        // R10 enable cleared mid-burst
        p_occ = 0;
        base_push = p_pushes;
        base_irq = p_irqs;
        pwr(2'd1, 32'h0000_0400);
        expect_play(32'h400, 8);
        pwr(2'd2, 32'd32);
        wait_push(base_push + 2);
        pwr(2'd0, 32'h0);
        cyc(20);
        chk(!p_req && !p_en, "R10 stopped when disabled", {30'h0, p_en, p_req}, 32'h0);
        chk(p_addr == 32'h400 + 32'(4 * (p_pushes - base_push)) &&
            32'(p_rem) == 32'd32 - 32'(4 * (p_pushes - base_push)), "R10 values kept",
            32'(p_rem), 32'd32 - 32'(4 * (p_pushes - base_push)));
        chk(p_irqs == base_irq, "R10 no interrupt", p_irqs, base_irq);
        pwr(2'd0, 32'h1);
        wait_push(base_push + 8);
        cyc(8);
        chk(p_rem == 0 && p_addr == 32'h420, "R10 resume finishes", p_addr, 32'h420);

        // R11 deferred address write
        p_occ = 0; p_lat = 6;
        pwr(2'd1, 32'h0000_0500);
        expect_play(32'h500, 1);
        expect_play(32'h800, 3);
        pwr(2'd2, 32'd16);
        for (int i = 0; i < 50 && !p_req; i++) @(negedge clk);
        pwr(2'd1, 32'h0000_0800);
        chk(p_addr == 32'h500 && p_req, "R11 address held in flight", p_addr, 32'h500);
        chk(p_maddr == 32'h500, "R12 request address stable", p_maddr, 32'h500);
        wait_push(p_pushes + 4);
        cyc(10);
        chk(p_addr == 32'h80C && p_rem == 0, "R11 new address used", p_addr, 32'h80C);
        chk(exp_play.size() == 0, "R11 word order", exp_play.size(), 0);

        // capture direction R7
        c_lat = 1;
        cap_fill(32'h900, 3, 0);
        cwr(2'd1, 32'h0000_0900);
        cwr(2'd2, 32'd20);
        cwr(2'd0, 32'h1);
        cyc(30);
        chk(c_writes == 3 && c_rem == 16'd8, "R7 capture limited by data", {16'h0, c_rem}, 32'd8);
        chk(c_irqs == 0, "R8 no capture interrupt yet", c_irqs, 0);
        cap_fill(32'h90C, 2, 3);
        cyc(30);
        chk(c_rem == 0 && c_addr == 32'h914, "R7 capture end address", c_addr, 32'h914);
        chk(c_irqs == 1 && c_writes == 5, "R8 capture interrupt", c_irqs, 1);

        done = 1'b1;
        finish_run();
    end
endmodule